// File: doc/BRIEF.md
# External Clock Bypass Controller

This block decides when the root clocks of a chip are switched to an external source and adapts its fixed clock dividers to the faster external clock. Two requesters exist. A life-cycle controller raises a request line and waits for an acknowledge. Software writes a 4-bit select register, and only one exact code counts as a request. A software request is honoured only while a DFT-permission input is high. The select register sits behind a one-bit write-enable that software can clear, but never set again before reset.

The merged request goes to an analog-side switch, which answers with a bypass acknowledge. Once that acknowledge is registered, the life-cycle requester is acknowledged. Every fixed divider then halves its ratio, and a divider applies the change only at the rising edge of its own output.

The block runs on a reference clock at twice the root rate. A divider of root ratio N toggles its output every N reference cycles, so a root divide-by-1 output toggles on every reference cycle.

Top module: `extclk_bypass_ctrl`

## Requirements
- R1: After reset the select register reads 4'h5 and the write-enable reads 1. `byp_req_o` and `lc_byp_ack_o` are 0. Divider channel k holds each output phase for 2^(k+1) reference cycles.
- R2: With `dft_allow_i` high, the select code 4'b1010 raises `byp_req_o` in the same cycle. Every other code leaves it low. Register reads return the stored select value.
- R3: While `dft_allow_i` is low, no select value raises `byp_req_o`.
- R4: Address 1 is the write-enable. A write with data bit 0 = 0 clears it. A write with bit 0 = 1 has no effect. Once cleared it stays 0 until reset.
- R5: While the write-enable is 0, writes to the select register (address 0) leave its stored value unchanged.
- R6: `byp_req_o` is the combinational OR of `lc_byp_req_i` and the qualified software request.
- R7: `byp_ack_i` is registered once. `lc_byp_ack_o` is high exactly when `lc_byp_req_i` is high and the registered acknowledge is high. It drops in the same cycle as the request.
- R8: While the registered acknowledge is high, whichever path requested it, channel k holds each phase for 2^k reference cycles. The base ratio returns after the acknowledge drops.
- R9: A divider takes a new ratio only at the rising edge of its output. The high and low phases of each period are therefore equal, and each equals either the old or the new half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, twice the root rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lc_byp_req_i | input | 1 | Life-cycle bypass request |
| lc_byp_ack_o | output | 1 | Life-cycle bypass acknowledge |
| dft_allow_i | input | 1 | DFT functions permitted |
| byp_req_o | output | 1 | Bypass request to the analog switch |
| byp_ack_i | input | 1 | Switch-complete acknowledge from the analog side |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 select, 1 write-enable |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Addressed register, zero-extended, combinational |
| div_clk_o | output | NUM_DIV | Divided clock outputs, channel k at bit k |

## Verification
Two situations are provoked on purpose. First, the life-cycle request and a qualified software select are held at the same time. The life-cycle request is then released while the bypass acknowledge stays high. The bench judges that `byp_req_o` stays high, that `lc_byp_ack_o` drops at once, and that the dividers stay stepped down. Second, the acknowledge is dropped one cycle after a divider output rises, in the middle of its high phase. The bench records the following phase lengths and requires both phases of every period to match, each at 2 or 4 cycles, ending at the base ratio.

// File: rtl/extbyp_pkg.sv
package extbyp_pkg;
   localparam int unsigned SEL_W = 4;
   localparam logic [SEL_W-1:0] SEL_EXT_CODE = 4'b1010;
   localparam logic [SEL_W-1:0] SEL_RESET    = 4'b0101;
   localparam int unsigned MAX_DIV = 6;

   typedef enum logic {
      ADDR_SEL = 1'b0,
      ADDR_WEN = 1'b1
   } reg_addr_e;
endpackage

// File: rtl/extbyp_regs.sv
module extbyp_regs
   import extbyp_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic             addr_i,
   input  logic [SEL_W-1:0] wdata_i,
   output logic [SEL_W-1:0] rdata_o,
   output logic [SEL_W-1:0] sel_o
);
   logic [SEL_W-1:0] sel_q;
   logic             wen_q;
   logic             sel_we, wen_clr;

   assign sel_we  = wr_i && (addr_i == ADDR_SEL) && wen_q;
   assign wen_clr = wr_i && (addr_i == ADDR_WEN) && !wdata_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= SEL_RESET;
         wen_q <= 1'b1;
      end else begin
         if (sel_we)  sel_q <= wdata_i;
         if (wen_clr) wen_q <= 1'b0;
      end
   end

   always_comb begin
      if (addr_i == ADDR_WEN) rdata_o = {{(SEL_W-1){1'b0}}, wen_q};
      else                    rdata_o = sel_q;
   end

   assign sel_o = sel_q;

   // R4: a cleared write-enable never returns to 1
   a_r4_wen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wen_q |=> !wen_q);
   // R5: the select value is frozen while locked
   a_r5_locked_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wen_q |=> $stable(sel_q));
endmodule

// File: rtl/extbyp_req.sv
module extbyp_req
   import extbyp_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             dft_allow_i,
   input  logic             lc_req_i,
   input  logic             byp_ack_i,
   output logic             byp_req_o,
   output logic             lc_ack_o,
   output logic             switched_o
);
   logic sw_req;
   logic ack_q;

   assign sw_req    = (sel_i == SEL_EXT_CODE) && dft_allow_i;
   assign byp_req_o = lc_req_i || sw_req;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ack_q <= 1'b0;
      else         ack_q <= byp_ack_i;
   end

   assign lc_ack_o   = lc_req_i && ack_q;
   assign switched_o = ack_q;

   // R3: no permission and no life-cycle request means no bypass request
   a_r3_no_dft_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dft_allow_i && !lc_req_i) |-> !byp_req_o);
   // R7: life-cycle acknowledge only while requested
   a_r7_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lc_ack_o |-> lc_req_i);
   // R7: life-cycle acknowledge rises only after a bypass acknowledge was seen
   a_r7_ack_follows_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lc_ack_o) |-> $past(byp_ack_i));
endmodule

// File: rtl/extbyp_div.sv
module extbyp_div #(
   parameter int unsigned BASE_LOG2 = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fast_req_i,
   output logic div_o
);
   localparam int unsigned CNT_W = BASE_LOG2 + 1;
   localparam logic [CNT_W-1:0] HALF_SLOW = CNT_W'(1) << BASE_LOG2;
   localparam logic [CNT_W-1:0] HALF_FAST = CNT_W'(1) << (BASE_LOG2 - 1);

   if (BASE_LOG2 < 1) begin : g_bad_log2
      $error("extbyp_div: BASE_LOG2 must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             out_q, fast_q, last;

   assign last = (cnt_q == ((fast_q ? HALF_FAST : HALF_SLOW) - CNT_W'(1)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         out_q  <= 1'b0;
         fast_q <= 1'b0;
      end else if (last) begin
         cnt_q <= '0;
         out_q <= ~out_q;
         if (!out_q) fast_q <= fast_req_i;   // period boundary: rising edge
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign div_o = out_q;

   // R9: ratio changes coincide with a rising output edge
   a_r9_switch_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fast_q != $past(fast_q)) |-> $rose(out_q));
endmodule

// File: rtl/extclk_bypass_ctrl.sv
module extclk_bypass_ctrl
   import extbyp_pkg::*;
#(
   parameter int unsigned NUM_DIV = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               lc_byp_req_i,
   output logic               lc_byp_ack_o,
   input  logic               dft_allow_i,
   output logic               byp_req_o,
   input  logic               byp_ack_i,
   input  logic               reg_wr_i,
   input  logic               reg_addr_i,
   input  logic [SEL_W-1:0]   reg_wdata_i,
   output logic [SEL_W-1:0]   reg_rdata_o,
   output logic [NUM_DIV-1:0] div_clk_o
);
   if (NUM_DIV < 1 || NUM_DIV > MAX_DIV) begin : g_bad_num
      $error("extclk_bypass_ctrl: NUM_DIV out of range");
   end

   logic [SEL_W-1:0] sel;
   logic             switched;

   extbyp_regs u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .rdata_o (reg_rdata_o),
      .sel_o   (sel)
   );

   extbyp_req u_req (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (sel),
      .dft_allow_i (dft_allow_i),
      .lc_req_i    (lc_byp_req_i),
      .byp_ack_i   (byp_ack_i),
      .byp_req_o   (byp_req_o),
      .lc_ack_o    (lc_byp_ack_o),
      .switched_o  (switched)
   );

   for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
      extbyp_div #(.BASE_LOG2(k + 1)) u_div (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .fast_req_i (switched),
         .div_o      (div_clk_o[k])
      );
   end
endmodule

// File: tb/test_extclk_bypass_ctrl.sv
module test_extclk_bypass_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_DIV = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lc_req = 0, lc_ack, dft = 0, byp_req, byp_ack = 0;
   logic wr = 0, addr = 0;
   logic [3:0] wdata = 0, rdata;
   logic [NUM_DIV-1:0] divo;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   extclk_bypass_ctrl #(.NUM_DIV(NUM_DIV)) i_extclk_bypass_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .lc_byp_req_i(lc_req), .lc_byp_ack_o(lc_ack),
      .dft_allow_i(dft), .byp_req_o(byp_req), .byp_ack_i(byp_ack),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .div_clk_o(divo));

   function automatic logic exp_req(logic [3:0] s, logic d, logic l);
      return l || (s == 4'b1010 && d);
   endfunction

   function automatic int exp_half(int ch, logic fast);
      return fast ? (1 << ch) : (1 << (ch + 1));
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wreg(logic a, logic [3:0] d);
      @(negedge clk); wr = 1; addr = a; wdata = d;
      @(negedge clk); wr = 0;
   endtask

   task automatic rreg(logic a, output logic [3:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic run_len(int ch, output int n);
      logic v;
      v = divo[ch]; n = 0;
      while (divo[ch] == v && n < 100) begin n++; @(negedge clk); end
   endtask

   task automatic sync_rise(int ch);
      int g = 0;
      @(negedge clk);
      while (divo[ch] != 1'b0 && g < 100) begin g++; @(negedge clk); end
      while (divo[ch] != 1'b1 && g < 200) begin g++; @(negedge clk); end
   endtask

   task automatic chk_phases(string req, logic fast);
      int h, l;
      for (int ch = 0; ch < NUM_DIV; ch++) begin
         sync_rise(ch);
         run_len(ch, h);
         run_len(ch, l);
         chk(req, h, exp_half(ch, fast));
         chk(req, l, exp_half(ch, fast));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [3:0] d, s;
      int runs[8];
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rreg(1'b0, d); chk("R1 sel reset", d, 5);
      rreg(1'b1, d); chk("R1 wen reset", d, 1);
      chk("R1 byp_req reset", byp_req, 0);
      chk("R1 lc_ack reset", lc_ack, 0);
      chk_phases("R1 base ratio", 1'b0);

      // R2/R3 random select and permission
      for (int i = 0; i < 40; i++) begin
         s = ($urandom % 4 == 0) ? 4'b1010 : 4'($urandom);
         wreg(1'b0, s);
         dft = 1'($urandom);
         @(negedge clk);
         rreg(1'b0, d);
         chk("R2 readback", d, s);
         chk(dft ? "R2 select decode" : "R3 dft blocks", byp_req, exp_req(s, dft, 1'b0));
      end
      wreg(1'b0, 4'b1010); dft = 0; #1;
      chk("R3 code without dft", byp_req, 0);
      dft = 1; #1;
      chk("R2 code with dft", byp_req, 1);
      wreg(1'b0, 4'b1011); #1;
      chk("R2 near code", byp_req, 0);

      // life-cycle path
      wreg(1'b0, 4'h5);
      lc_req = 1; #1;
      chk("R6 lc forwards", byp_req, 1);
      @(negedge clk);
      chk("R7 no ack before switch", lc_ack, 0);
      byp_ack = 1;
      @(negedge clk);
      chk("R7 ack after switch", lc_ack, 1);
      repeat (20) @(negedge clk);
      chk_phases("R8 lc stepped", 1'b1);
      // both requesters, then life-cycle releases
      wreg(1'b0, 4'b1010);
      lc_req = 0; #1;
      chk("R6 sw keeps request", byp_req, 1);
      chk("R7 ack drops with req", lc_ack, 0);
      chk_phases("R8 still stepped", 1'b1);
      wreg(1'b0, 4'h5); #1;
      chk("R6 request released", byp_req, 0);
      byp_ack = 0;
      repeat (20) @(negedge clk);
      chk_phases("R8 restored", 1'b0);

      // software path and boundary behaviour
      wreg(1'b0, 4'b1010); #1;
      chk("R2 sw request", byp_req, 1);
      byp_ack = 1;
      @(negedge clk);
      chk("R7 no lc ack on sw path", lc_ack, 0);
      repeat (20) @(negedge clk);
      chk_phases("R8 sw stepped", 1'b1);
      sync_rise(1);
      byp_ack = 0;
      for (int j = 0; j < 8; j++) run_len(1, runs[j]);
      for (int j = 0; j < 8; j += 2) begin
         chk("R9 equal phases", runs[j], runs[j+1]);
         chk("R9 legal phase", int'(runs[j] == 2 || runs[j] == 4), 1);
      end
      chk("R9 ends at base", runs[6], 4);

      // lock behaviour
      wreg(1'b1, 4'h1);
      rreg(1'b1, d); chk("R4 write 1 ignored", d, 1);
      wreg(1'b0, 4'h3);
      rreg(1'b0, d); chk("R5 unlocked write", d, 3);
      wreg(1'b1, 4'h0);
      rreg(1'b1, d); chk("R4 cleared", d, 0);
      wreg(1'b1, 4'h1);
      rreg(1'b1, d); chk("R4 stays cleared", d, 0);
      wreg(1'b0, 4'b1010);
      rreg(1'b0, d); chk("R5 locked write ignored", d, 3);
      chk("R5 no request when locked", byp_req, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule